// File: doc/BRIEF.md
# Dual-Port Synchronous SRAM with Cross-Port Forwarding

A single-clock word memory with two independent access ports, X and Y. Each port has its own address, write data, write enable, a pair of chip selects, a forward control and an output enable. On each rising clock edge both ports register their request, and the two ports may each read, write or forward in the same cycle. Forwarding sends a port's own write data to the opposite port's read output, bypassing the array.

Requests at the same address on both ports follow fixed rules. A read sees the word as it was before any write in that cycle. When both ports write the same word, port Y's data is kept. The array depth is a parameter: the full size is 131,072 words of 36 bits with 17-bit addresses, and a smaller default keeps simulation cheap. The first clock edge after reset is a dummy cycle, and requests presented at that edge are dropped. Bidirectional data pins are split into a data input, a registered data output and a drive-enable output.

Top module: `dpsram_pt`

## Requirements
- R1: A port that is selected with write enable high (1) stores its write data at its address. A later read of that address, with write enable low (0), returns the word on the reading port's data output.
- R2: Read and forward results appear on the data output at the clock edge after the one that registers the command, and not before. While a port's output gets no read or forward, it holds its last value.
- R3: Both ports operate concurrently and independently at different addresses in the same cycle.
- R4: When port X is selected and its forward input is high, port X's write data appears on port Y's output. This takes precedence over a read on port Y in the same cycle.
- R5: When port Y is selected and its forward input is high, port Y's write data appears on port X's output. This takes precedence over a read on port X in the same cycle.
- R6: Two reads of the same address in the same cycle both return the stored word.
- R7: A read and a write to the same address in the same cycle return the old word to the reader, and the new word is stored afterwards. This holds with either port as the writer.
- R8: Two writes to the same address in the same cycle store port Y's data.
- R9: A port is selected only when its active-low chip select is 0 and its active-high chip select is 1. A deselected port does not write, does not read (its output holds), and does not forward.
- R10: Each drive-enable output follows its port's output-enable input combinationally, with no clock edge.
- R11: Requests at the first clock edge after reset is released are ignored: no write, no read and no forward takes effect.
- R12: Asynchronous reset clears both data outputs to zero. It does not clear the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_addr_i | input | ADDR_W | Port X word address |
| x_wdata_i | input | DATA_W | Port X write / forward data |
| x_we_i | input | 1 | Port X write enable (1 write, 0 read) |
| x_ce_n_i | input | 1 | Port X chip select, active low |
| x_ce_i | input | 1 | Port X chip select, active high |
| x_pt_i | input | 1 | Port X forward to port Y output |
| x_oe_i | input | 1 | Port X output enable |
| x_rdata_o | output | DATA_W | Port X registered data output |
| x_drive_o | output | 1 | Port X output drive enable |
| y_addr_i | input | ADDR_W | Port Y word address |
| y_wdata_i | input | DATA_W | Port Y write / forward data |
| y_we_i | input | 1 | Port Y write enable (1 write, 0 read) |
| y_ce_n_i | input | 1 | Port Y chip select, active low |
| y_ce_i | input | 1 | Port Y chip select, active high |
| y_pt_i | input | 1 | Port Y forward to port X output |
| y_oe_i | input | 1 | Port Y output enable |
| y_rdata_o | output | DATA_W | Port Y registered data output |
| y_drive_o | output | 1 | Port Y output drive enable |

## Verification
The bench applies these patterns:
- Single-port writes followed by reads from the other port show that the array is shared and that the output register adds one cycle.
- Simultaneous traffic at distinct addresses, then crossed reads, separates independent operation from any port aliasing.
- Forwarding is paired with a read on the target port, so it shows whether the forward or the read wins.
- Same-address read-read, read-write (both directions) and write-write pairs show read-before-write ordering and port Y priority.
- Partial chip selects, the async output-enable toggle, and commands placed exactly on the dummy edge after a reset show which requests are blocked.

// File: rtl/dpsram_pkg.sv
package dpsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/dpsram_port_in.sv
module dpsram_port_in
  import dpsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              ce_n_i,
  input  logic              ce_i,
  input  logic              pt_i,
  output op_e               op_o,
  output logic              pt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic sel;
  // both selects active and past the dummy cycle
  assign sel = armed_i & ~ce_n_i & ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= OP_IDLE;
      pt_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      op_o    <= !sel ? OP_IDLE : (we_i ? OP_WRITE : OP_READ);
      pt_o    <= sel & pt_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/dpsram_array.sv
module dpsram_array
  import dpsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               x_op_i,
  input  logic [ADDR_W-1:0] x_addr_i,
  input  logic [DATA_W-1:0] x_wdata_i,
  input  op_e               y_op_i,
  input  logic [ADDR_W-1:0] y_addr_i,
  input  logic [DATA_W-1:0] y_wdata_i,
  output logic [DATA_W-1:0] x_rd_o,
  output logic [DATA_W-1:0] y_rd_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic x_wr, y_wr, ww_hit;

  assign x_wr   = (x_op_i == OP_WRITE);
  assign y_wr   = (y_op_i == OP_WRITE);
  assign ww_hit = x_wr && y_wr && (x_addr_i == y_addr_i);

  // reads sample pre-edge contents: read-before-write on collision
  assign x_rd_o = mem[x_addr_i];
  assign y_rd_o = mem[y_addr_i];

  always_ff @(posedge clk_i) begin
    if (x_wr && !ww_hit) mem[x_addr_i] <= x_wdata_i;
    if (y_wr)            mem[y_addr_i] <= y_wdata_i;
  end

  a_r8_y_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ww_hit |=> mem[$past(y_addr_i)] == $past(y_wdata_i));

  a_r1_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_wr && !ww_hit) |=> mem[$past(x_addr_i)] == $past(x_wdata_i));
endmodule

// File: rtl/dpsram_port_out.sv
module dpsram_port_out
  import dpsram_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic              fwd_vld_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (fwd_vld_i)         q_o <= fwd_data_i;
    else if (op_i == OP_READ)   q_o <= rd_i;
  end

  a_r4_r5_fwd_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_i |=> q_o == $past(fwd_data_i));

  a_r1_read_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_READ && !fwd_vld_i) |=> q_o == $past(rd_i));

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_READ && !fwd_vld_i) |=> $stable(q_o));
endmodule

// File: rtl/dpsram_pt.sv
module dpsram_pt
  import dpsram_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] x_addr_i,
  input  logic [DATA_W-1:0] x_wdata_i,
  input  logic              x_we_i,
  input  logic              x_ce_n_i,
  input  logic              x_ce_i,
  input  logic              x_pt_i,
  input  logic              x_oe_i,
  output logic [DATA_W-1:0] x_rdata_o,
  output logic              x_drive_o,
  input  logic [ADDR_W-1:0] y_addr_i,
  input  logic [DATA_W-1:0] y_wdata_i,
  input  logic              y_we_i,
  input  logic              y_ce_n_i,
  input  logic              y_ce_i,
  input  logic              y_pt_i,
  input  logic              y_oe_i,
  output logic [DATA_W-1:0] y_rdata_o,
  output logic              y_drive_o
);
  localparam int NP = 2;  // index 0 = X, 1 = Y

  logic              armed_q;
  logic [ADDR_W-1:0] p_addr  [NP];
  logic [DATA_W-1:0] p_wdata [NP];
  logic              p_we    [NP];
  logic              p_ce_n  [NP];
  logic              p_ce    [NP];
  logic              p_pt    [NP];
  op_e               c_op    [NP];
  logic              c_pt    [NP];
  logic [ADDR_W-1:0] c_addr  [NP];
  logic [DATA_W-1:0] c_wdata [NP];
  logic [DATA_W-1:0] rd      [NP];
  logic [DATA_W-1:0] q       [NP];

  assign p_addr[0]  = x_addr_i;   assign p_addr[1]  = y_addr_i;
  assign p_wdata[0] = x_wdata_i;  assign p_wdata[1] = y_wdata_i;
  assign p_we[0]    = x_we_i;     assign p_we[1]    = y_we_i;
  assign p_ce_n[0]  = x_ce_n_i;   assign p_ce_n[1]  = y_ce_n_i;
  assign p_ce[0]    = x_ce_i;     assign p_ce[1]    = y_ce_i;
  assign p_pt[0]    = x_pt_i;     assign p_pt[1]    = y_pt_i;

  // first edge after reset is a dummy cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    dpsram_port_in #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .armed_i (armed_q),
      .addr_i  (p_addr[g]),
      .wdata_i (p_wdata[g]),
      .we_i    (p_we[g]),
      .ce_n_i  (p_ce_n[g]),
      .ce_i    (p_ce[g]),
      .pt_i    (p_pt[g]),
      .op_o    (c_op[g]),
      .pt_o    (c_pt[g]),
      .addr_o  (c_addr[g]),
      .wdata_o (c_wdata[g])
    );
    // forward source is the opposite port
    dpsram_port_out #(.DATA_W(DATA_W)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .op_i       (c_op[g]),
      .rd_i       (rd[g]),
      .fwd_vld_i  (c_pt[NP-1-g]),
      .fwd_data_i (c_wdata[NP-1-g]),
      .q_o        (q[g])
    );
  end

  dpsram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .x_op_i    (c_op[0]),
    .x_addr_i  (c_addr[0]),
    .x_wdata_i (c_wdata[0]),
    .y_op_i    (c_op[1]),
    .y_addr_i  (c_addr[1]),
    .y_wdata_i (c_wdata[1]),
    .x_rd_o    (rd[0]),
    .y_rd_o    (rd[1])
  );

  assign x_rdata_o = q[0];
  assign y_rdata_o = q[1];
  assign x_drive_o = x_oe_i;
  assign y_drive_o = y_oe_i;

  a_r11_dummy_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(x_rdata_o) && $stable(y_rdata_o));

  a_r12_reset_out: assert property (@(posedge clk_i)
    !rst_ni |-> (x_rdata_o == '0) && (y_rdata_o == '0));
endmodule

// File: tb/dpsram_pt_test.sv
`timescale 1ns/1ps
module dpsram_pt_test;
  localparam int DW = 36;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] x_addr = '0, y_addr = '0;
  logic [DW-1:0] x_wdata = '0, y_wdata = '0;
  logic x_we = 0, x_ce_n = 1, x_ce = 0, x_pt = 0, x_oe = 0;
  logic y_we = 0, y_ce_n = 1, y_ce = 0, y_pt = 0, y_oe = 0;
  logic [DW-1:0] x_rdata, y_rdata;
  logic x_drive, y_drive;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dpsram_pt #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .x_addr_i(x_addr), .x_wdata_i(x_wdata), .x_we_i(x_we), .x_ce_n_i(x_ce_n),
    .x_ce_i(x_ce), .x_pt_i(x_pt), .x_oe_i(x_oe), .x_rdata_o(x_rdata), .x_drive_o(x_drive),
    .y_addr_i(y_addr), .y_wdata_i(y_wdata), .y_we_i(y_we), .y_ce_n_i(y_ce_n),
    .y_ce_i(y_ce), .y_pt_i(y_pt), .y_oe_i(y_oe), .y_rdata_o(y_rdata), .y_drive_o(y_drive)
  );

  localparam logic [DW-1:0] D1 = 36'h1_2345_6789, D2 = 36'h2_0F0F_0F0F;
  localparam logic [DW-1:0] VA = 36'hA_AAAA_0001, VB = 36'hB_BBBB_0002;
  localparam logic [DW-1:0] VP = 36'hC_0DE0_0003, VQ = 36'hD_0DE0_0004;
  localparam logic [DW-1:0] VC = 36'h3_CCCC_0005, VE = 36'hE_EEEE_0006;
  localparam logic [DW-1:0] VF = 36'hF_FFFF_0007, VG = 36'h7_7777_0008;
  localparam logic [DW-1:0] VH = 36'h5_5555_0009, VJ = 36'h6_6666_000A;
  localparam logic [DW-1:0] VK = 36'h9_9999_000B, JUNK = 36'h8_DEAD_BEEF;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_x(input logic s, input logic w, input logic p,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    x_ce_n = !s; x_ce = s; x_we = w; x_pt = p; x_addr = a; x_wdata = d;
  endtask

  task automatic set_y(input logic s, input logic w, input logic p,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    y_ce_n = !s; y_ce = s; y_we = w; y_pt = p; y_addr = a; y_wdata = d;
  endtask

  // command captured at next edge, result visible one edge later
  task automatic run();
    @(posedge clk); @(negedge clk);
    set_x(0, 0, 0, '0, '0); set_y(0, 0, 0, '0, '0);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 x out after reset", x_rdata, '0);
    check("R12 y out after reset", y_rdata, '0);
    check("R10 x drive off", {35'd0, x_drive}, '0);
  endtask

  task automatic t_write_read();
    set_x(1, 1, 0, 3, D1); run();
    set_y(1, 0, 0, 3, '0); run();
    check("R1 y reads x write", y_rdata, D1);
    set_x(1, 0, 0, 3, '0); run();
    check("R1 x reads back", x_rdata, D1);
    set_x(1, 1, 0, 4, D2); run();
    set_y(1, 0, 0, 4, '0);
    @(posedge clk); @(negedge clk);
    check("R2 not before next edge", y_rdata, D1);
    set_y(0, 0, 0, '0, '0);
    @(posedge clk); @(negedge clk);
    check("R2 one edge later", y_rdata, D2);
    repeat (2) @(negedge clk);
    check("R2 holds when idle", y_rdata, D2);
  endtask

  task automatic t_concurrent();
    set_x(1, 1, 0, 10, VA); set_y(1, 1, 0, 11, VB); run();
    set_x(1, 0, 0, 11, '0); set_y(1, 0, 0, 10, '0); run();
    check("R3 x reads y word", x_rdata, VB);
    check("R3 y reads x word", y_rdata, VA);
  endtask

  task automatic t_fwd_x();
    set_x(1, 0, 1, 11, VP); set_y(1, 0, 0, 10, '0); run();
    check("R4 x forward beats y read", y_rdata, VP);
    check("R4 x own read", x_rdata, VB);
  endtask

  task automatic t_fwd_y();
    set_x(1, 0, 0, 10, '0); set_y(1, 0, 1, 11, VQ); run();
    check("R5 y forward beats x read", x_rdata, VQ);
    check("R5 y own read", y_rdata, VB);
  endtask

  task automatic t_read_read();
    set_x(1, 0, 0, 10, '0); set_y(1, 0, 0, 10, '0); run();
    check("R6 x same-addr read", x_rdata, VA);
    check("R6 y same-addr read", y_rdata, VA);
  endtask

  task automatic t_read_write();
    set_x(1, 1, 0, 20, VC); run();
    set_x(1, 0, 0, 20, '0); set_y(1, 1, 0, 20, VE); run();
    check("R7 x reads old word", x_rdata, VC);
    set_x(1, 0, 0, 20, '0); run();
    check("R7 y write landed", x_rdata, VE);
    set_y(1, 0, 0, 20, '0); set_x(1, 1, 0, 20, VC); run();
    check("R7 y reads old word", y_rdata, VE);
    set_y(1, 0, 0, 20, '0); run();
    check("R7 x write landed", y_rdata, VC);
  endtask

  task automatic t_write_write();
    set_x(1, 1, 0, 30, VF); set_y(1, 1, 0, 30, VG); run();
    set_x(1, 0, 0, 30, '0); run();
    check("R8 y data kept", x_rdata, VG);
  endtask

  task automatic t_select();
    // x: low select inactive -> write must not land
    set_x(1, 1, 0, 10, JUNK); x_ce_n = 1'b1;
    // y: high select inactive -> read must not update output
    set_y(1, 0, 0, 10, '0); y_ce = 1'b0;
    run();
    check("R9 y deselected read holds", y_rdata, VC);
    set_x(1, 0, 0, 10, '0); run();
    check("R9 x deselected write blocked", x_rdata, VA);
    set_x(1, 0, 1, 0, JUNK); x_ce = 1'b0;
    set_y(1, 0, 0, 10, '0); run();
    check("R9 x deselected forward blocked", y_rdata, VA);
    check("R9 x deselected read holds", x_rdata, VA);
  endtask

  task automatic t_oe();
    #0.5 x_oe = 1'b1; y_oe = 1'b0;
    #0.2 check("R10 x drive on", {35'd0, x_drive}, 36'd1);
    check("R10 y drive off", {35'd0, y_drive}, 36'd0);
    y_oe = 1'b1; x_oe = 1'b0;
    #0.2 check("R10 x drive off", {35'd0, x_drive}, 36'd0);
    check("R10 y drive on", {35'd0, y_drive}, 36'd1);
    @(negedge clk);
  endtask

  task automatic t_dummy();
    set_x(1, 1, 0, 5, VH); run();
    rst_n = 1'b0;
    #1 check("R12 x cleared by reset", x_rdata, '0);
    check("R12 y cleared by reset", y_rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    set_x(1, 1, 0, 5, VJ); set_y(1, 0, 1, 5, VK);
    run();
    check("R11 y forward ignored", x_rdata, '0);
    check("R11 y read ignored", y_rdata, '0);
    set_y(1, 0, 0, 5, '0); run();
    check("R11 x write ignored", y_rdata, VH);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);  // pass dummy edge
    t_write_read();
    t_concurrent();
    t_fwd_x();
    t_fwd_y();
    t_read_read();
    t_read_write();
    t_write_write();
    t_select();
    t_oe();
    t_dummy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule